// File: doc/BRIEF.md
# Pulse-Swallow Synthesizer Divider Chain

This block is the digital divider section of a frequency synthesizer. The synthesizer oscillator runs the block's only clock. On that clock the block divides the oscillator by a dual-modulus ratio, and it divides a slower reference square wave, sampled on the same clock, down to the phase-comparison rate. Both divided streams leave the block as one-cycle pulses. A lock detector compares the timing of the two pulse streams. A test tap can put any of several internal signals onto a single status pin in place of the lock flag.

The oscillator-side ratio comes from a prescaler that switches between divide-by-32 and divide-by-33, plus a main counter and a swallow counter. For the first swallow-count prescaler periods of each main period the prescaler divides by 33. For the rest it divides by 32. The total ratio is therefore main × 32 + swallow. A single power-up input enables all of the counters and the lock detector together. While the block is powered down, the divider settings are captured continuously. While it runs, new settings are loaded only at a terminal count.

Top module: `pswallow_divider`

## Requirements
- R1: While `pu_i` is high, `pc_div_o` pulses once every M × 32 + S oscillator cycles. M is 32, 33, 34 or 35 for `main_code_i` values 0, 1, 2 and 3. S is `swallow_code_i`, from 0 to 31.
- R2: While `pu_i` is high, `ref_div_o` pulses once for every R rising edges of `ref_clk_i`. R is 3 for `ref_code_i` = 0 and 6 for `ref_code_i` = 2.
- R3: `ref_code_i` = 1, and the unassigned code 3, both select a reference ratio of 4.
- R4: Every pulse on `ref_div_o` and on `pc_div_o` is exactly one clock cycle wide.
- R5: A change to the divider settings made while running takes effect only at the next terminal count. The pulse interval in progress keeps its old length, and the interval after it has the new length.
- R6: `lock_o` rises after 16 consecutive comparison periods in which the reference pulse and the oscillator-side pulse fall within 2 clock cycles of each other. It stays low before the 16th such period.
- R7: A single comparison period whose pulses are more than 2 cycles apart clears `lock_o`.
- R8: `tap_sel_i` drives `status_o` as follows: 0 gives the lock flag, 1 gives the reference pulse, 2 gives the oscillator-side pulse, and codes 5 to 7 give the lock flag.
- R9: `tap_sel_i` = 3 drives `status_o` with a square wave that changes level on every reference pulse. `tap_sel_i` = 4 drives it with a square wave that changes level every 1024 reference pulses, which is the reference rate divided by 2048.
- R10: While `pu_i` is low, no pulses appear on either divided output, `lock_o` is low, and the counters hold their start state.
- R11: After reset, `ref_div_o`, `pc_div_o`, `lock_o` and `status_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pu_i | input | 1 | Power-up for the dividers and the lock detector |
| ref_clk_i | input | 1 | Reference square wave, sampled on clk_i |
| ref_code_i | input | 2 | Reference divide select |
| main_code_i | input | 2 | Main counter select (32 + code) |
| swallow_code_i | input | 5 | Swallow count |
| tap_sel_i | input | 3 | Status pin source select |
| ref_div_o | output | 1 | Divided reference pulse |
| pc_div_o | output | 1 | Divided oscillator pulse |
| lock_o | output | 1 | Lock flag |
| status_o | output | 1 | Test-tap or lock output |

## Verification
A corrupted prescaler or main/swallow state shows up as a `pc_div_o` interval that is wrong by a multiple of one or 32 cycles. This is visible at the first terminal count, which comes at most about 1151 cycles later. A wrong reference count shows as a wrong `ref_div_o` interval within one reference period, and that same error also drops or withholds `lock_o` at the next comparison. A mistake in settings reload timing appears as a runt or stretched interval immediately around the terminal count where the settings change. Errors in the slow test divider appear only after 1024 reference pulses.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int unsigned PRESC_LO = 32;

  typedef enum logic [2:0] {
    TAP_LOCK     = 3'd0,
    TAP_REF      = 3'd1,
    TAP_PC       = 3'd2,
    TAP_REF_HALF = 3'd3,
    TAP_REF_SLOW = 3'd4
  } tap_sel_e;

  function automatic logic [2:0] ref_ratio(input logic [1:0] code);
    case (code)
      2'b00:   return 3'd3;
      2'b10:   return 3'd6;
      default: return 3'd4;  // code 11 falls back to 4
    endcase
  endfunction

  function automatic logic [5:0] main_modulus(input logic [1:0] code);
    return 6'd32 + {4'd0, code};
  endfunction
endpackage

// File: rtl/pss_ref_div.sv
module pss_ref_div (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       ref_clk_i,
  input  logic [1:0] code_i,
  output logic       pulse_o
);
  import pss_pkg::*;

  logic       ref_q;
  logic [2:0] cnt_q, ratio_q;
  logic       rise;

  assign rise = ref_clk_i & ~ref_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ref_q <= 1'b0;
    else         ref_q <= ref_clk_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= 3'd4;
      pulse_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q   <= '0;
      ratio_q <= ref_ratio(code_i);
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (rise) begin
        if (cnt_q == ratio_q - 3'd1) begin
          cnt_q   <= '0;
          ratio_q <= ref_ratio(code_i);
          pulse_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/pss_prog_div.sv
module pss_prog_div #(
  parameter int unsigned SC_W  = 5,
  parameter int unsigned MC_W  = 2,
  parameter int unsigned PRESC = pss_pkg::PRESC_LO
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [MC_W-1:0] main_code_i,
  input  logic [SC_W-1:0] swallow_i,
  output logic            pulse_o
);
  import pss_pkg::*;

  localparam int unsigned P_W = $clog2(PRESC + 1);
  localparam int unsigned M_W = 6;

  logic [P_W-1:0]  p_q, p_last;
  logic [M_W-1:0]  m_q, smc_q;
  logic [SC_W-1:0] ssc_q;
  logic            swallow_phase, pres_end, main_end;

  // first ssc prescaler periods run at PRESC+1
  assign swallow_phase = m_q < M_W'(ssc_q);
  assign p_last        = swallow_phase ? P_W'(PRESC) : P_W'(PRESC - 1);
  assign pres_end      = p_q == p_last;
  assign main_end      = m_q == smc_q - M_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_q     <= '0;
      m_q     <= '0;
      smc_q   <= M_W'(PRESC);
      ssc_q   <= '0;
      pulse_o <= 1'b0;
    end else if (!en_i) begin
      p_q     <= '0;
      m_q     <= '0;
      smc_q   <= main_modulus(main_code_i);
      ssc_q   <= swallow_i;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= 1'b0;
      if (pres_end) begin
        p_q <= '0;
        if (main_end) begin
          m_q     <= '0;
          smc_q   <= main_modulus(main_code_i);
          ssc_q   <= swallow_i;
          pulse_o <= 1'b1;
        end else begin
          m_q <= m_q + M_W'(1);
        end
      end else begin
        p_q <= p_q + P_W'(1);
      end
    end
  end
endmodule

// File: rtl/pss_lock_det.sv
module pss_lock_det #(
  parameter int unsigned LOCK_COUNT = 16,
  parameter int unsigned WIN        = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ref_pulse_i,
  input  logic pc_pulse_i,
  output logic lock_o
);
  localparam int unsigned AGE_W = $clog2(2 * WIN + 2);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam int unsigned CNT_W = $clog2(LOCK_COUNT + 1);

  logic [AGE_W-1:0] ref_age_q, pc_age_q;
  logic [CNT_W-1:0] hits_q;
  logic             eval, hit;

  // judge WIN cycles after the reference pulse, window spans +/-WIN
  assign eval = ref_age_q == AGE_W'(WIN);
  assign hit  = pc_age_q <= AGE_W'(2 * WIN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_age_q <= AGE_MAX;
      pc_age_q  <= AGE_MAX;
    end else if (!en_i) begin
      ref_age_q <= AGE_MAX;
      pc_age_q  <= AGE_MAX;
    end else begin
      if (ref_pulse_i)             ref_age_q <= '0;
      else if (ref_age_q != AGE_MAX) ref_age_q <= ref_age_q + AGE_W'(1);
      if (pc_pulse_i)              pc_age_q <= '0;
      else if (pc_age_q != AGE_MAX)  pc_age_q <= pc_age_q + AGE_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hits_q <= '0;
      lock_o <= 1'b0;
    end else if (!en_i) begin
      hits_q <= '0;
      lock_o <= 1'b0;
    end else if (eval) begin
      if (hit) begin
        if (hits_q != CNT_W'(LOCK_COUNT)) hits_q <= hits_q + CNT_W'(1);
        if (hits_q >= CNT_W'(LOCK_COUNT - 1)) lock_o <= 1'b1;
      end else begin
        hits_q <= '0;
        lock_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pss_test_tap.sv
module pss_test_tap #(
  parameter int unsigned SLOW_LOG2 = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       ref_pulse_i,
  input  logic       pc_pulse_i,
  input  logic       lock_i,
  input  logic [2:0] sel_i,
  output logic       status_o
);
  import pss_pkg::*;

  localparam int unsigned SC_W = SLOW_LOG2 - 1;

  logic            half_q, slow_q;
  logic [SC_W-1:0] slow_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q     <= 1'b0;
      slow_q     <= 1'b0;
      slow_cnt_q <= '0;
    end else if (!en_i) begin
      half_q     <= 1'b0;
      slow_q     <= 1'b0;
      slow_cnt_q <= '0;
    end else if (ref_pulse_i) begin
      half_q     <= ~half_q;
      slow_cnt_q <= slow_cnt_q + SC_W'(1);
      if (&slow_cnt_q) slow_q <= ~slow_q;
    end
  end

  always_comb begin
    case (tap_sel_e'(sel_i))
      TAP_REF:      status_o = ref_pulse_i;
      TAP_PC:       status_o = pc_pulse_i;
      TAP_REF_HALF: status_o = half_q;
      TAP_REF_SLOW: status_o = slow_q;
      default:      status_o = lock_i;
    endcase
  end
endmodule

// File: rtl/pswallow_divider.sv
module pswallow_divider #(
  parameter int unsigned LOCK_COUNT = 16,
  parameter int unsigned LOCK_WIN   = 2,
  parameter int unsigned SLOW_LOG2  = 11,
  parameter int unsigned SC_W       = 5,
  parameter int unsigned MC_W       = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pu_i,
  input  logic            ref_clk_i,
  input  logic [1:0]      ref_code_i,
  input  logic [MC_W-1:0] main_code_i,
  input  logic [SC_W-1:0] swallow_code_i,
  input  logic [2:0]      tap_sel_i,
  output logic            ref_div_o,
  output logic            pc_div_o,
  output logic            lock_o,
  output logic            status_o
);
  logic ref_pulse, pc_pulse, lock;

  pss_ref_div u_ref_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (pu_i),
    .ref_clk_i(ref_clk_i),
    .code_i   (ref_code_i),
    .pulse_o  (ref_pulse)
  );

  pss_prog_div #(.SC_W(SC_W), .MC_W(MC_W)) u_prog_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pu_i),
    .main_code_i(main_code_i),
    .swallow_i  (swallow_code_i),
    .pulse_o    (pc_pulse)
  );

  pss_lock_det #(.LOCK_COUNT(LOCK_COUNT), .WIN(LOCK_WIN)) u_lock_det (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pu_i),
    .ref_pulse_i(ref_pulse),
    .pc_pulse_i (pc_pulse),
    .lock_o     (lock)
  );

  pss_test_tap #(.SLOW_LOG2(SLOW_LOG2)) u_test_tap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (pu_i),
    .ref_pulse_i(ref_pulse),
    .pc_pulse_i (pc_pulse),
    .lock_i     (lock),
    .sel_i      (tap_sel_i),
    .status_o   (status_o)
  );

  assign ref_div_o = ref_pulse;
  assign pc_div_o  = pc_pulse;
  assign lock_o    = lock;
endmodule

// File: rtl/pss_checker.sv
module pss_checker #(
  parameter int unsigned LOCK_COUNT = 16,
  parameter int unsigned MIN_PERIOD = 1024
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pu_i,
  input logic [2:0] tap_sel_i,
  input logic       ref_div_o,
  input logic       pc_div_o,
  input logic       lock_o,
  input logic       status_o
);
  localparam int unsigned PER_W = $clog2(2 * MIN_PERIOD);
  localparam int unsigned RC_W  = $clog2(LOCK_COUNT + 1);

  logic [PER_W-1:0] per_q;
  logic             seen_q;
  logic [RC_W-1:0]  refs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      seen_q <= 1'b0;
      refs_q <= '0;
    end else if (!pu_i) begin
      per_q  <= '0;
      seen_q <= 1'b0;
      refs_q <= '0;
    end else begin
      if (pc_div_o) begin
        per_q  <= PER_W'(1);
        seen_q <= 1'b1;
      end else if (per_q != '1) begin
        per_q <= per_q + PER_W'(1);
      end
      if (ref_div_o && refs_q != RC_W'(LOCK_COUNT)) refs_q <= refs_q + RC_W'(1);
    end
  end

  assert_ref_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_div_o |=> !ref_div_o);
  assert_pc_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_div_o |=> !pc_div_o);
  assert_pc_min_period_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pc_div_o && seen_q && pu_i) |-> per_q >= PER_W'(MIN_PERIOD));
  assert_lock_after_refs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> refs_q >= RC_W'(LOCK_COUNT));
  assert_tap_ref_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_sel_i == 3'd1) |-> status_o == ref_div_o);
  assert_tap_lock_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_sel_i == 3'd0) |-> status_o == lock_o);
  assert_powerdown_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pu_i |=> (!pc_div_o && !ref_div_o && !lock_o));
endmodule

bind pswallow_divider pss_checker #(.LOCK_COUNT(LOCK_COUNT)) u_pss_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .pu_i     (pu_i),
  .tap_sel_i(tap_sel_i),
  .ref_div_o(ref_div_o),
  .pc_div_o (pc_div_o),
  .lock_o   (lock_o),
  .status_o (status_o)
);

// File: tb/pswallow_divider_test.sv
module pswallow_divider_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  typedef struct packed {
    logic [1:0]  rc;
    logic [1:0]  mc;
    logic [4:0]  sc;
    logic [3:0]  exp_r;
    logic [10:0] exp_n;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{2'b00, 2'b00, 5'd0,  4'd3, 11'd1024},
    '{2'b01, 2'b01, 5'd5,  4'd4, 11'd1061},
    '{2'b10, 2'b10, 5'd31, 4'd6, 11'd1119},
    '{2'b11, 2'b11, 5'd31, 4'd4, 11'd1151},
    '{2'b00, 2'b11, 5'd0,  4'd3, 11'd1120}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pu_i = 1'b0;
  logic ref_clk_i = 1'b0;
  logic [1:0] ref_code_i = '0;
  logic [1:0] main_code_i = '0;
  logic [4:0] swallow_code_i = '0;
  logic [2:0] tap_sel_i = '0;
  logic ref_div_o, pc_div_o, lock_o, status_o;

  int cyc = 0;
  int checks = 0, fails = 0;
  int rph = 0, rk = 3;
  int pc_cnt = 0, pc_last = 0, pc_prev = 0;
  int ref_cnt = 0, ref_last = 0, ref_prev = 0;
  int st_cnt = 0, st_last = 0, st_prev = 0;
  int chg_cnt = 0, chg_last = 0, chg_prev = 0;
  int wide_cnt = 0;
  logic pc_s = 1'b0, ref_s = 1'b0, st_s = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pswallow_divider uut (
    .clk_i(clk), .rst_ni(rst_ni), .pu_i(pu_i), .ref_clk_i(ref_clk_i),
    .ref_code_i(ref_code_i), .main_code_i(main_code_i),
    .swallow_code_i(swallow_code_i), .tap_sel_i(tap_sel_i),
    .ref_div_o(ref_div_o), .pc_div_o(pc_div_o), .lock_o(lock_o),
    .status_o(status_o)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (pc_div_o && !pc_s) begin pc_prev = pc_last; pc_last = cyc; pc_cnt++; end
    if (ref_div_o && !ref_s) begin ref_prev = ref_last; ref_last = cyc; ref_cnt++; end
    if ((pc_div_o && pc_s) || (ref_div_o && ref_s)) wide_cnt++;
    if (status_o && !st_s) begin st_prev = st_last; st_last = cyc; st_cnt++; end
    if (status_o != st_s) begin chg_prev = chg_last; chg_last = cyc; chg_cnt++; end
    pc_s = pc_div_o; ref_s = ref_div_o; st_s = status_o;
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ref_clk_i = (rph % (2 * rk)) >= rk;
    rph++;
    #1;
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    int b, s0;
    steps(4);
    check(!ref_div_o && !pc_div_o, "R11 dividers in reset", int'(ref_div_o | pc_div_o), 0);
    check(!lock_o, "R11 lock in reset", int'(lock_o), 0);
    check(!status_o, "R11 status in reset", int'(status_o), 0);
    rst_ni = 1'b1;
    steps(3);

    // ratio table: R1, R2, R3
    rk = 3;
    foreach (VEC[i]) begin
      pu_i = 1'b0;
      ref_code_i = VEC[i].rc; main_code_i = VEC[i].mc; swallow_code_i = VEC[i].sc;
      steps(4);
      pu_i = 1'b1;
      b = pc_cnt;
      while (pc_cnt < b + 3) step();
      check(pc_last - pc_prev == int'(VEC[i].exp_n), "R1 pc interval",
            pc_last - pc_prev, int'(VEC[i].exp_n));
      check(ref_last - ref_prev == 2 * rk * int'(VEC[i].exp_r),
            (VEC[i].rc == 2'b11) ? "R3 ref interval" : "R2 ref interval",
            ref_last - ref_prev, 2 * rk * int'(VEC[i].exp_r));
    end

    // lock acquisition: N=1056, R=4, ref period 264
    pu_i = 1'b0;
    ref_code_i = 2'b01; main_code_i = 2'b01; swallow_code_i = 5'd0;
    rk = 132; rph = 0;
    steps(rk + 2);
    pu_i = 1'b1;
    b = pc_cnt;
    while (pc_cnt < b + 14) step();
    steps(10);
    check(!lock_o, "R6 lock before 16 periods", int'(lock_o), 0);
    while (pc_cnt < b + 18) step();
    steps(10);
    check(lock_o, "R6 lock after 16 periods", int'(lock_o), 1);
    check((pc_last - ref_last <= 2) && (ref_last - pc_last <= 2), "R6 edge offset",
          pc_last - ref_last, 0);

    // settings change mid-interval: R5, then drift clears lock: R7
    swallow_code_i = 5'd2;
    b = pc_cnt;
    while (pc_cnt < b + 1) step();
    check(pc_last - pc_prev == 1056, "R5 interval in progress", pc_last - pc_prev, 1056);
    while (pc_cnt < b + 2) step();
    check(pc_last - pc_prev == 1058, "R5 new interval", pc_last - pc_prev, 1058);
    while (pc_cnt < b + 5) step();
    steps(10);
    check(!lock_o, "R7 lock cleared by miss", int'(lock_o), 0);

    // test tap: R8, R9
    pu_i = 1'b0;
    ref_code_i = 2'b00; main_code_i = 2'b00; swallow_code_i = 5'd0;
    rk = 3; rph = 0;
    steps(4);
    pu_i = 1'b1;
    tap_sel_i = 3'd1;
    s0 = st_cnt;
    while (st_cnt < s0 + 3) step();
    check(st_last - st_prev == 18, "R8 tap ref pulse", st_last - st_prev, 18);
    tap_sel_i = 3'd2;
    s0 = st_cnt;
    while (st_cnt < s0 + 3) step();
    check(st_last - st_prev == 1024, "R8 tap pc pulse", st_last - st_prev, 1024);
    tap_sel_i = 3'd3;
    s0 = chg_cnt;
    while (chg_cnt < s0 + 3) step();
    check(chg_last - chg_prev == 18, "R9 tap ref half", chg_last - chg_prev, 18);
    tap_sel_i = 3'd4;
    s0 = chg_cnt;
    while (chg_cnt < s0 + 3) step();
    check(chg_last - chg_prev == 18432, "R9 tap ref slow", chg_last - chg_prev, 18432);
    tap_sel_i = 3'd0;
    steps(2);
    check(status_o == lock_o, "R8 tap lock", int'(status_o), int'(lock_o));
    tap_sel_i = 3'd6;
    steps(2);
    check(status_o == lock_o, "R8 tap fallback", int'(status_o), int'(lock_o));

    // power-down: R10
    pu_i = 1'b0;
    steps(5);
    b = pc_cnt; s0 = ref_cnt;
    steps(3000);
    check(pc_cnt == b, "R10 no pc pulses", pc_cnt - b, 0);
    check(ref_cnt == s0, "R10 no ref pulses", ref_cnt - s0, 0);
    check(!lock_o, "R10 lock low", int'(lock_o), 0);

    check(wide_cnt == 0, "R4 pulse width", wide_cnt, 0);
    summary();
  end
endmodule